// File: doc/BRIEF.md
# I2C Controller Status Byte

This block keeps the eight-bit status word of an I2C bus controller. Three of its bits are sticky flags with their own set and clear rules. The first marks the controller as the active bus master. The second records a lost arbitration. The third records that an address byte beginning with a reserved upper nibble was received. The bus engine drives these flags through single-cycle event pulses. The block also sees the controller enable bit, and it finds the enable's falling edge by itself.

The other five bits are copies of engine conditions: address match, transmit direction, acknowledge seen, start seen and stop seen. They are registered each cycle and held at zero while the controller is disabled.

Software reads the word through a small read port, either as the whole byte or as one selected bit. Both kinds of read count as an access that clears the arbitration flag on the following cycle. The read itself returns the value held before that clear.

Top module: `i2c_status_unit`

## Requirements
- R1: After reset every bit of the status byte reads as 0.
- R2: With `rd_bit_mode` low, `rd_data` returns the status byte in the same cycle. Bit 7 is master-active, 6 arbitration-lost, 5 extension-code, 4 address match, 3 transmit, 2 acknowledge, 1 start seen and 0 stop seen. With `rd_bit_mode` high, `rd_data[0]` returns the bit chosen by `rd_bit_sel` and `rd_data[7:1]` is 0.
- R3: A `ev_start_gen` pulse sets the master-active bit, which is visible from the next cycle.
- R4: The master-active bit clears on `ev_stop_det`, on `ev_release` or on an enable falling edge. A `ev_start_gen` in the same cycle overrides those clears. `ev_arb_lost` overrides `ev_start_gen`.
- R5: An `ev_arb_lost` pulse sets the arbitration-lost bit and clears the master-active bit in the same update.
- R6: A `rd_strobe` in byte or bit mode clears the arbitration-lost bit on the cycle after the strobe. The read returns the old value. An `ev_arb_lost` in the same cycle as the strobe leaves the bit set.
- R7: An `ev_addr_clk8` pulse sets the extension-code bit when `rx_addr[7:4]` is 4'b0000 or 4'b1111. Any other upper nibble leaves the bit unchanged.
- R8: The extension-code bit clears on `ev_start_det`, on `ev_stop_det`, on `ev_release` or on an enable falling edge. A set in the same cycle takes priority.
- R9: When `ctl_enable` goes from 1 to 0 between two consecutive clock edges, the master-active, arbitration-lost and extension-code bits all clear.
- R10: Bits 4..0 take the engine inputs `eng_coincide`, `eng_transmit`, `eng_ack`, `eng_start_seen` and `eng_stop_seen`, registered each cycle. They read 0 in every cycle that follows a cycle with `ctl_enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable bit |
| ev_start_gen | input | 1 | Pulse: this controller generated a start |
| ev_start_det | input | 1 | Pulse: start condition detected on the bus |
| ev_stop_det | input | 1 | Pulse: stop condition detected on the bus |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_addr_clk8 | input | 1 | Pulse: eighth clock rising edge of an address byte |
| rx_addr | input | ADDR_W | Received address byte, valid with `ev_addr_clk8` |
| ev_release | input | 1 | Pulse: local release command |
| eng_coincide | input | 1 | Engine: address match |
| eng_transmit | input | 1 | Engine: transmit direction |
| eng_ack | input | 1 | Engine: acknowledge detected |
| eng_start_seen | input | 1 | Engine: start seen |
| eng_stop_seen | input | 1 | Engine: stop seen |
| rd_strobe | input | 1 | Read access strobe |
| rd_bit_mode | input | 1 | 1 = single-bit read, 0 = byte read |
| rd_bit_sel | input | 3 | Bit index for single-bit reads |
| rd_data | output | 8 | Read data |

## Verification
The properties take every event input to be a clean, synchronous level sampled at the rising edge. For the enable falling-edge check they require `ctl_enable` to have been sampled high at an edge after reset had been released. The property on the pass-through bits assumes that reads are taken in byte mode. The bench drives all inputs on the falling clock edge and holds each event for exactly one rising edge. It changes `ctl_enable` only after reset has been released, and it samples `rd_data` shortly after the falling edge at which the strobe is raised. In that way every check sees the register state that follows the preceding rising edge.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;

    localparam int STAT_W   = 8;
    localparam int PASS_W   = 5;
    localparam int SEL_W    = $clog2(STAT_W);

    localparam int POS_MST  = 7;
    localparam int POS_ARB  = 6;
    localparam int POS_EXT  = 5;

    typedef struct packed {
        logic mst;
        logic arb;
        logic ext;
    } flag_t;

    typedef struct packed {
        logic coin;
        logic xmit;
        logic ack;
        logic sta;
        logic sto;
    } pass_t;

    function automatic logic nibble_reserved(input logic [3:0] nib);
        return (nib == 4'b0000) || (nib == 4'b1111);
    endfunction

endpackage

// File: rtl/i2c_status_en_track.sv
module i2c_status_en_track (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic en_fall
);
    logic en_d, en_q;

    always_comb begin
        en_d = enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_fall = en_q & ~enable;
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_status_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_fall,
    input  logic             start_gen,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             arb_lost,
    input  logic             addr_clk8,
    input  logic [NIB_W-1:0] addr_nib,
    input  logic             release_cmd,
    input  logic             rd_access,
    output flag_t            flags
);
    flag_t flag_d, flag_q;
    logic  ext_hit;

    always_comb begin
        ext_hit = addr_clk8 && nibble_reserved(addr_nib[3:0]);
        flag_d  = flag_q;

        // master-active: arbitration loss > start generated > clears
        if (arb_lost)                                flag_d.mst = 1'b0;
        else if (start_gen)                          flag_d.mst = 1'b1;
        else if (stop_det || release_cmd || en_fall) flag_d.mst = 1'b0;

        // arbitration-lost: set wins over read clear and enable fall
        if (arb_lost)                     flag_d.arb = 1'b1;
        else if (rd_access || en_fall)    flag_d.arb = 1'b0;

        // extension-code: set wins over all clears
        if (ext_hit)                                             flag_d.ext = 1'b1;
        else if (start_det || stop_det || release_cmd || en_fall) flag_d.ext = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/i2c_status_passthru.sv
module i2c_status_passthru
    import i2c_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  pass_t eng_in,
    output pass_t pass_out
);
    pass_t pass_d, pass_q;

    always_comb begin
        pass_d = enable ? eng_in : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= '0;
        else        pass_q <= pass_d;
    end

    assign pass_out = pass_q;
endmodule

// File: rtl/i2c_status_rdport.sv
module i2c_status_rdport
    import i2c_status_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    input  logic              bit_mode,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [STAT_W-1:0] rdata
);
    logic [STAT_W-1:0] sel_onehot;
    logic              sel_bit;

    for (genvar i = 0; i < STAT_W; i++) begin : g_sel
        assign sel_onehot[i] = (bit_sel == SEL_W'(i)) & stat[i];
    end

    always_comb begin
        sel_bit = |sel_onehot;
        if (bit_mode) rdata = {{(STAT_W-1){1'b0}}, sel_bit};
        else          rdata = stat;
    end
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
    import i2c_status_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              ev_start_gen,
    input  logic              ev_start_det,
    input  logic              ev_stop_det,
    input  logic              ev_arb_lost,
    input  logic              ev_addr_clk8,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              ev_release,
    input  logic              eng_coincide,
    input  logic              eng_transmit,
    input  logic              eng_ack,
    input  logic              eng_start_seen,
    input  logic              eng_stop_seen,
    input  logic              rd_strobe,
    input  logic              rd_bit_mode,
    input  logic [2:0]        rd_bit_sel,
    output logic [7:0]        rd_data
);
    localparam int NIB_W = 4;

    logic              en_fall;
    flag_t             flags;
    pass_t             eng_in, pass_out;
    logic [STAT_W-1:0] stat_byte;
    logic [NIB_W-1:0]  addr_nib;
    logic              unused_addr_low;

    assign addr_nib        = rx_addr[ADDR_W-1 -: NIB_W];
    assign unused_addr_low = ^rx_addr[ADDR_W-NIB_W-1:0];

    assign eng_in = '{coin: eng_coincide, xmit: eng_transmit, ack: eng_ack,
                      sta: eng_start_seen, sto: eng_stop_seen};

    i2c_status_en_track u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctl_enable),
        .en_fall (en_fall)
    );

    i2c_status_flags #(.NIB_W(NIB_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_fall     (en_fall),
        .start_gen   (ev_start_gen),
        .start_det   (ev_start_det),
        .stop_det    (ev_stop_det),
        .arb_lost    (ev_arb_lost),
        .addr_clk8   (ev_addr_clk8),
        .addr_nib    (addr_nib),
        .release_cmd (ev_release),
        .rd_access   (rd_strobe),
        .flags       (flags)
    );

    i2c_status_passthru u_pass (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctl_enable),
        .eng_in   (eng_in),
        .pass_out (pass_out)
    );

    always_comb begin
        stat_byte          = '0;
        stat_byte[POS_MST] = flags.mst;
        stat_byte[POS_ARB] = flags.arb;
        stat_byte[POS_EXT] = flags.ext;
        stat_byte[PASS_W-1:0] = pass_out;
    end

    i2c_status_rdport u_rd (
        .stat     (stat_byte),
        .bit_mode (rd_bit_mode),
        .bit_sel  (rd_bit_sel),
        .rdata    (rd_data)
    );
endmodule

// File: rtl/i2c_status_unit_chk.sv
module i2c_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_enable,
    input logic       ev_start_gen,
    input logic       ev_stop_det,
    input logic       ev_start_det,
    input logic       ev_arb_lost,
    input logic       ev_addr_clk8,
    input logic [7:0] rx_addr,
    input logic       ev_release,
    input logic       rd_strobe,
    input logic       rd_bit_mode,
    input logic [7:0] rd_data,
    input logic [7:0] stat_byte
);
    assert_bitmode_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bit_mode |-> rd_data[7:1] == 7'd0);

    assert_master_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_gen && !ev_arb_lost) |=> stat_byte[7]);

    assert_master_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_stop_det || ev_release) && !ev_start_gen) |=> !stat_byte[7]);

    assert_arb_kills_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> (stat_byte[6] && !stat_byte[7]));

    assert_read_clears_arb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !ev_arb_lost) |=> !stat_byte[6]);

    assert_ext_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_clk8 && (rx_addr[7:4] == 4'h0 || rx_addr[7:4] == 4'hF)) |=> stat_byte[5]);

    assert_ext_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_start_det || ev_stop_det || ev_release) && !ev_addr_clk8) |=> !stat_byte[5]);

    assert_enable_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ctl_enable) && !ev_arb_lost && !ev_start_gen && !ev_addr_clk8)
        |-> ##1 (stat_byte[7:5] == 3'b000));

    assert_pass_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> (stat_byte[4:0] == 5'd0));
endmodule

bind i2c_status_unit i2c_status_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_enable   (ctl_enable),
    .ev_start_gen (ev_start_gen),
    .ev_stop_det  (ev_stop_det),
    .ev_start_det (ev_start_det),
    .ev_arb_lost  (ev_arb_lost),
    .ev_addr_clk8 (ev_addr_clk8),
    .rx_addr      (rx_addr),
    .ev_release   (ev_release),
    .rd_strobe    (rd_strobe),
    .rd_bit_mode  (rd_bit_mode),
    .rd_data      (rd_data),
    .stat_byte    (stat_byte)
);

// File: tb/i2c_status_unit_test.sv
`timescale 1ns/1ps
module i2c_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_enable = 1'b0;
    logic       ev_start_gen = 1'b0, ev_start_det = 1'b0, ev_stop_det = 1'b0;
    logic       ev_arb_lost = 1'b0, ev_addr_clk8 = 1'b0, ev_release = 1'b0;
    logic [7:0] rx_addr = 8'h00;
    logic       eng_coincide = 1'b0, eng_transmit = 1'b0, eng_ack = 1'b0;
    logic       eng_start_seen = 1'b0, eng_stop_seen = 1'b0;
    logic       rd_strobe = 1'b0, rd_bit_mode = 1'b0;
    logic [2:0] rd_bit_sel = 3'd0;
    logic [7:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    i2c_status_unit uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
        .ev_start_gen(ev_start_gen), .ev_start_det(ev_start_det),
        .ev_stop_det(ev_stop_det), .ev_arb_lost(ev_arb_lost),
        .ev_addr_clk8(ev_addr_clk8), .rx_addr(rx_addr), .ev_release(ev_release),
        .eng_coincide(eng_coincide), .eng_transmit(eng_transmit), .eng_ack(eng_ack),
        .eng_start_seen(eng_start_seen), .eng_stop_seen(eng_stop_seen),
        .rd_strobe(rd_strobe), .rd_bit_mode(rd_bit_mode), .rd_bit_sel(rd_bit_sel),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // one-cycle event pulse; bits: {sg, sd, pd, al, c8, rl}
    task automatic fire(input logic [5:0] ev, input logic [7:0] addr);
        @(negedge clk);
        {ev_start_gen, ev_start_det, ev_stop_det, ev_arb_lost, ev_addr_clk8, ev_release} = ev;
        rx_addr = addr;
        @(negedge clk);
        {ev_start_gen, ev_start_det, ev_stop_det, ev_arb_lost, ev_addr_clk8, ev_release} = '0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] exp);
        @(negedge clk);
        rd_strobe = 1'b1; rd_bit_mode = 1'b0;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic read_bit(input string req, input logic [2:0] sel, input logic exp);
        @(negedge clk);
        rd_strobe = 1'b1; rd_bit_mode = 1'b1; rd_bit_sel = sel;
        #1 check(req, rd_data, {7'd0, exp});
        @(negedge clk);
        rd_strobe = 1'b0; rd_bit_mode = 1'b0;
    endtask

    localparam logic [5:0] SG = 6'b100000, SD = 6'b010000, PD = 6'b001000;
    localparam logic [5:0] AL = 6'b000100, C8 = 6'b000010, RL = 6'b000001;

    task automatic t_reset;
        read_byte("R1 reset value", 8'h00);
    endtask

    task automatic t_master;
        fire(SG, 8'h00);       read_byte("R3 start sets master", 8'h80);
        fire(PD, 8'h00);       read_byte("R4 stop clears master", 8'h00);
        fire(SG, 8'h00);
        fire(RL, 8'h00);       read_byte("R4 release clears master", 8'h00);
        fire(SG | PD, 8'h00);  read_byte("R4 start beats stop", 8'h80);
        fire(SG | AL, 8'h00);  read_byte("R4 arb loss beats start", 8'h40);
        read_byte("R6 cleared after read", 8'h00);
    endtask

    task automatic t_arb;
        fire(SG, 8'h00);
        fire(AL, 8'h00);       read_byte("R5 arb set, master cleared", 8'h40);
        read_byte("R6 byte read cleared arb", 8'h00);
        fire(AL, 8'h00);       read_bit("R6 bit read sees arb", 3'd6, 1'b1);
        read_byte("R6 bit read cleared arb", 8'h00);
        // set in the same cycle as a read
        @(negedge clk);
        ev_arb_lost = 1'b1; rd_strobe = 1'b1; rd_bit_mode = 1'b0;
        #1 check("R6 read returns old value", rd_data, 8'h00);
        @(negedge clk);
        ev_arb_lost = 1'b0; rd_strobe = 1'b0;
        read_byte("R6 set wins over read clear", 8'h40);
        read_byte("R6 cleared afterwards", 8'h00);
    endtask

    task automatic t_ext;
        fire(C8, 8'h0A);       read_byte("R7 nibble 0000 sets ext", 8'h20);
        fire(SD, 8'h00);       read_byte("R8 start det clears ext", 8'h00);
        fire(C8, 8'hF3);       read_byte("R7 nibble 1111 sets ext", 8'h20);
        fire(PD, 8'h00);       read_byte("R8 stop clears ext", 8'h00);
        fire(C8, 8'h50);       read_byte("R7 other nibble ignored", 8'h00);
        fire(C8, 8'h7F);       read_bit("R7 nibble 0111 ignored", 3'd5, 1'b0);
        fire(C8, 8'h0F);
        fire(RL, 8'h00);       read_byte("R8 release clears ext", 8'h00);
        fire(C8 | SD, 8'hFF);  read_byte("R8 set beats clear", 8'h20);
        fire(SD, 8'h00);
    endtask

    task automatic t_enable;
        fire(AL, 8'h00);
        fire(SG, 8'h00);
        fire(C8, 8'h00);
        read_bit("R2 bit read of master", 3'd7, 1'b1);
        fire(AL, 8'h00);
        @(negedge clk); ctl_enable = 1'b0;
        read_byte("R9 enable fall clears flags", 8'h00);
        @(negedge clk); ctl_enable = 1'b1;
    endtask

    task automatic t_pass;
        @(negedge clk);
        {eng_coincide, eng_transmit, eng_ack, eng_start_seen, eng_stop_seen} = 5'b10110;
        read_byte("R10 pass-through pattern 10110", 8'h16);
        read_bit("R2 bit read bit 4", 3'd4, 1'b1);
        read_bit("R2 bit read bit 0", 3'd0, 1'b0);
        @(negedge clk);
        {eng_coincide, eng_transmit, eng_ack, eng_start_seen, eng_stop_seen} = 5'b11111;
        ctl_enable = 1'b0;
        read_byte("R10 forced zero while disabled", 8'h00);
        @(negedge clk); ctl_enable = 1'b1;
        read_byte("R10 all ones after enable", 8'h1F);
        fire(SG, 8'h00);
        read_byte("R2 byte layout master and pass", 8'h9F);
        @(negedge clk);
        {eng_coincide, eng_transmit, eng_ack, eng_start_seen, eng_stop_seen} = 5'b01001;
        read_byte("R10 pattern 01001", 8'h89);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(negedge clk); ctl_enable = 1'b1;
        t_master();
        t_arb();
        t_ext();
        t_enable();
        t_pass();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule